// File: doc/BRIEF.md
# Supply Fault Detector with Hysteresis

This block supervises one supply rail in the digital domain. An upstream converter delivers 8-bit voltage codes with a valid strobe. The block compares each code against a programmable upper limit and a programmable lower limit. Each limit has its own 5-bit hysteresis band, so a fault that has tripped stays latched until the code has moved back past the limit by the band width.

The register file selects which limit drives the fault: the upper one, the lower one, or both together as a window. A glitch qualifier then requires the selected raw fault to hold for a programmed time before the fault output asserts. The output drops in the same cycle that the raw fault clears.

The register file is byte-wide and has five locations. The select register also holds a polarity bit and a range bit. These two bits only affect a range indication output and do not change the comparison.

Top module: `sfd_supervisor`

## Requirements
- R1: After reset, the upper threshold (address 0) reads 0xFF. The upper hysteresis (address 1), lower threshold (address 2), lower hysteresis (address 3) and select (address 4) read 0x00, and fault_out is 0.
- R2: A register write shows up on cfg_rdata from the next cycle. Bits 7:5 of both hysteresis registers always read 0. Bit 3 of the select register always reads 0. Addresses 5 to 7 read 0x00.
- R3: The upper flag sets on a valid sample whose code is strictly greater than the upper threshold. It clears on a valid sample whose code is strictly below the upper threshold minus the upper hysteresis, where that difference floors at 0. Any other sample leaves the flag unchanged.
- R4: The lower flag sets on a valid sample whose code is strictly below the lower threshold. It clears on a valid sample whose code is strictly above the lower threshold plus the lower hysteresis, where that sum caps at 255. Any other sample leaves the flag unchanged.
- R5: Select bits 1:0 choose the raw fault: 00 gives the upper flag, 01 gives the lower flag, and 10 gives the OR of both flags.
- R6: When select bits 1:0 are 11, fault_out stays 0 whatever the samples are.
- R7: With delay code 0 (select bits 6:4), fault_out follows the raw fault with no extra cycle. The flag register is updated at the sample edge, and fault_out is high in the cycle that follows.
- R8: Delay codes 1 to 7 stand for 5, 10, 20, 30, 50, 75 and 100 µs. fault_out asserts only once the raw fault has been high for that number of microseconds times CLK_PER_US clock cycles. It drops in the first cycle in which the raw fault is low.
- R9: range_hi equals select bit 2 when select bit 7 is 0. When select bit 7 is 1 (negative mode), range_hi is 0 whatever bit 2 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write enable |
| cfg_addr | input | AW | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for cfg_addr |
| smp_vld | input | 1 | Sample strobe |
| smp_code | input | SMP_W | Sample voltage code |
| range_hi | output | 1 | High range indication |
| fault_out | output | 1 | Qualified fault |

## Verification
On every cycle, the embedded properties check three things. First, each hysteresis flag changes only at a sample strobe. Second, a qualified fault with a non-zero delay code rises only after the raw fault was already present. Third, the forbidden fault type never lets the output assert. The exact trip and release levels need the bench's scenarios to show them, including the floor at 0 and the cap at 255. So do the hold-in-band behaviour, the exact cycle where the qualification delay ends, and the register readback masking. A cycle-accurate reference model covers these against long random runs of held codes and random configurations.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

   typedef enum logic [1:0] {
      FT_OVER   = 2'b00,
      FT_UNDER  = 2'b01,
      FT_WINDOW = 2'b10,
      FT_BAD    = 2'b11
   } ftype_e;

   localparam logic [2:0] A_OV_THR = 3'd0;
   localparam logic [2:0] A_OV_HY  = 3'd1;
   localparam logic [2:0] A_UV_THR = 3'd2;
   localparam logic [2:0] A_UV_HY  = 3'd3;
   localparam logic [2:0] A_SEL    = 3'd4;

   localparam int unsigned MAX_DLY_US = 100;

   function automatic int unsigned dly_us(input logic [2:0] code);
      case (code)
         3'd0:    return 0;
         3'd1:    return 5;
         3'd2:    return 10;
         3'd3:    return 20;
         3'd4:    return 30;
         3'd5:    return 50;
         3'd6:    return 75;
         default: return 100;
      endcase
   endfunction

endpackage

// File: rtl/sfd_regs.sv
module sfd_regs
   import sfd_pkg::*;
#(
   parameter int SMP_W = 8,
   parameter int HY_W  = 5,
   parameter int AW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    addr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   output logic [SMP_W-1:0] ov_thr,
   output logic [HY_W-1:0]  ov_hy,
   output logic [SMP_W-1:0] uv_thr,
   output logic [HY_W-1:0]  uv_hy,
   output logic             neg_pol,
   output logic [2:0]       gf_code,
   output logic             rsel,
   output ftype_e           ftype
);

   localparam int PADH = 8 - HY_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ov_thr  <= '1;
         ov_hy   <= '0;
         uv_thr  <= '0;
         uv_hy   <= '0;
         neg_pol <= 1'b0;
         gf_code <= '0;
         rsel    <= 1'b0;
         ftype   <= FT_OVER;
      end else if (wr_en) begin
         case (addr)
            AW'(A_OV_THR): ov_thr <= wdata[SMP_W-1:0];
            AW'(A_OV_HY):  ov_hy  <= wdata[HY_W-1:0];
            AW'(A_UV_THR): uv_thr <= wdata[SMP_W-1:0];
            AW'(A_UV_HY):  uv_hy  <= wdata[HY_W-1:0];
            AW'(A_SEL): begin
               neg_pol <= wdata[7];
               gf_code <= wdata[6:4];
               rsel    <= wdata[2];
               ftype   <= ftype_e'(wdata[1:0]);
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         AW'(A_OV_THR): rdata = ov_thr;
         AW'(A_OV_HY):  rdata = {{PADH{1'b0}}, ov_hy};
         AW'(A_UV_THR): rdata = uv_thr;
         AW'(A_UV_HY):  rdata = {{PADH{1'b0}}, uv_hy};
         AW'(A_SEL):    rdata = {neg_pol, gf_code, 1'b0, rsel, ftype};
         default:       rdata = 8'h00;
      endcase
   end

endmodule

// File: rtl/sfd_thresh.sv
module sfd_thresh #(
   parameter int W     = 8,
   parameter int HY_W  = 5,
   parameter bit ABOVE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld,
   input  logic [W-1:0]  code,
   input  logic [W-1:0]  thr,
   input  logic [HY_W-1:0] hy,
   output logic          flag
);

   localparam int PAD = W - HY_W;

   logic [W-1:0] hy_ext;
   logic         trip;
   logic         rel;
   logic [W-1:0] rel_lvl;

   assign hy_ext = {{PAD{1'b0}}, hy};

   generate
      if (ABOVE) begin : g_upper
         assign rel_lvl = (thr > hy_ext) ? (thr - hy_ext) : '0;
         assign trip    = code > thr;
         assign rel     = code < rel_lvl;
      end else begin : g_lower
         logic [W:0] sum;
         assign sum     = {1'b0, thr} + {1'b0, hy_ext};
         assign rel_lvl = sum[W] ? '1 : sum[W-1:0];
         assign trip    = code < thr;
         assign rel     = code > rel_lvl;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (vld) begin
         if (!flag && trip)
            flag <= 1'b1;
         else if (flag && rel)
            flag <= 1'b0;
      end
   end

   // R3 R4
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(vld));

   // R3 R4
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(vld));

endmodule

// File: rtl/sfd_qual.sv
module sfd_qual
   import sfd_pkg::*;
#(
   parameter int CLK_PER_US = 250
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       raw,
   input  logic [2:0] gf_code,
   output logic       qual
);

   localparam int unsigned MAXC = MAX_DLY_US * CLK_PER_US;
   localparam int          CW   = $clog2(MAXC + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   assign lim = CW'(dly_us(gf_code) * CLK_PER_US);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!raw) begin
         cnt <= '0;
      end else if (cnt != CW'(MAXC)) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign qual = raw && (cnt >= lim);

   // R8
   qual_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(qual) && (gf_code != 3'd0)) |-> $past(raw));

endmodule

// File: rtl/sfd_supervisor.sv
module sfd_supervisor
   import sfd_pkg::*;
#(
   parameter int SMP_W      = 8,
   parameter int HY_W       = 5,
   parameter int AW         = 3,
   parameter int CLK_PER_US = 250
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [AW-1:0]    cfg_addr,
   input  logic [7:0]       cfg_wdata,
   output logic [7:0]       cfg_rdata,
   input  logic             smp_vld,
   input  logic [SMP_W-1:0] smp_code,
   output logic             range_hi,
   output logic             fault_out
);

   generate
      if (SMP_W != 8) begin : g_bad_w
         $error("SMP_W must be 8 for byte-wide registers");
      end
      if (HY_W < 1 || HY_W >= SMP_W) begin : g_bad_hy
         $error("HY_W must lie between 1 and SMP_W-1");
      end
      if (AW < 3) begin : g_bad_aw
         $error("AW must reach address 4");
      end
      if (CLK_PER_US < 1) begin : g_bad_clk
         $error("CLK_PER_US must be at least 1");
      end
   endgenerate

   logic [SMP_W-1:0] ov_thr, uv_thr;
   logic [HY_W-1:0]  ov_hy, uv_hy;
   logic             neg_pol, rsel;
   logic [2:0]       gf_code;
   ftype_e           ftype;
   logic             ov_flag, uv_flag;
   logic             raw;

   sfd_regs #(.SMP_W(SMP_W), .HY_W(HY_W), .AW(AW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr),
      .addr    (cfg_addr),
      .wdata   (cfg_wdata),
      .rdata   (cfg_rdata),
      .ov_thr  (ov_thr),
      .ov_hy   (ov_hy),
      .uv_thr  (uv_thr),
      .uv_hy   (uv_hy),
      .neg_pol (neg_pol),
      .gf_code (gf_code),
      .rsel    (rsel),
      .ftype   (ftype)
   );

   sfd_thresh #(.W(SMP_W), .HY_W(HY_W), .ABOVE(1'b1)) u_over (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (smp_vld),
      .code  (smp_code),
      .thr   (ov_thr),
      .hy    (ov_hy),
      .flag  (ov_flag)
   );

   sfd_thresh #(.W(SMP_W), .HY_W(HY_W), .ABOVE(1'b0)) u_under (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (smp_vld),
      .code  (smp_code),
      .thr   (uv_thr),
      .hy    (uv_hy),
      .flag  (uv_flag)
   );

   always_comb begin
      case (ftype)
         FT_OVER:   raw = ov_flag;
         FT_UNDER:  raw = uv_flag;
         FT_WINDOW: raw = ov_flag | uv_flag;
         default:   raw = 1'b0;
      endcase
   end

   sfd_qual #(.CLK_PER_US(CLK_PER_US)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     (raw),
      .gf_code (gf_code),
      .qual    (fault_out)
   );

   assign range_hi = rsel & ~neg_pol;

   // R6
   bad_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ftype == FT_BAD) |-> !fault_out);

endmodule

// File: tb/sfd_supervisor_test.sv
`timescale 1ns/1ps
module sfd_supervisor_test;

   localparam int CPU  = 2;
   localparam int MAXC = 100 * CPU;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       smp_vld = 1'b0;
   logic [7:0] smp_code = '0;
   logic       range_hi, fault_out;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sfd_supervisor #(.CLK_PER_US(CPU)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smp_vld(smp_vld),
      .smp_code(smp_code), .range_hi(range_hi), .fault_out(fault_out)
   );

   // reference model
   int m_ovt, m_ovh, m_uvt, m_uvh, m_gf, m_ft, m_cnt;
   bit m_neg, m_rs, m_ov, m_uv;

   function automatic int dly(input int c);
      case (c)
         0: return 0;  1: return 5;  2: return 10; 3: return 20;
         4: return 30; 5: return 50; 6: return 75; default: return 100;
      endcase
   endfunction

   function automatic bit m_raw();
      case (m_ft)
         0: return m_ov;
         1: return m_uv;
         2: return m_ov | m_uv;
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit m_fault();
      return m_raw() && (m_cnt >= dly(m_gf) * CPU);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ovt = 255; m_ovh = 0; m_uvt = 0; m_uvh = 0;
         m_gf = 0; m_ft = 0; m_neg = 0; m_rs = 0;
         m_ov = 0; m_uv = 0; m_cnt = 0;
      end else begin
         if (!m_raw()) m_cnt = 0;
         else if (m_cnt < MAXC) m_cnt = m_cnt + 1;
         if (smp_vld) begin
            int c, lo, hi;
            c  = smp_code;
            lo = (m_ovt > m_ovh) ? m_ovt - m_ovh : 0;
            hi = (m_uvt + m_uvh > 255) ? 255 : m_uvt + m_uvh;
            if (!m_ov && c > m_ovt) m_ov = 1;
            else if (m_ov && c < lo) m_ov = 0;
            if (!m_uv && c < m_uvt) m_uv = 1;
            else if (m_uv && c > hi) m_uv = 0;
         end
         if (cfg_wr) begin
            case (cfg_addr)
               3'd0: m_ovt = cfg_wdata;
               3'd1: m_ovh = cfg_wdata[4:0];
               3'd2: m_uvt = cfg_wdata;
               3'd3: m_uvh = cfg_wdata[4:0];
               3'd4: begin
                  m_neg = cfg_wdata[7]; m_gf = cfg_wdata[6:4];
                  m_rs = cfg_wdata[2]; m_ft = cfg_wdata[1:0];
               end
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // continuous model comparison (R3 R4 R5 R6 R7 R8 R9)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R8 fault vs model", fault_out, m_fault());
         chk("R9 range vs model", range_hi, (m_rs && !m_neg) ? 1 : 0);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      cfg_addr = 3'(a);
      #1 d = cfg_rdata;
   endtask

   task automatic smp(input int c);
      @(negedge clk);
      smp_vld = 1'b1; smp_code = 8'(c);
      @(negedge clk);
      smp_vld = 1'b0;
   endtask

   task automatic cfg(input int ovt, input int ovh, input int uvt, input int uvh, input int sel);
      wr(0, ovt); wr(1, ovh); wr(2, uvt); wr(3, uvh); wr(4, sel);
   endtask

   initial begin
      int d;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(0, d); chk("R1 ov thr", d, 8'hFF);
      for (int a = 1; a < 5; a++) begin
         rd(a, d); chk("R1 zero reg", d, 0);
      end
      chk("R1 fault", fault_out, 0);

      // R2 write, readback and masking
      wr(1, 8'hFF); rd(1, d); chk("R2 ov hyst mask", d, 8'h1F);
      wr(3, 8'hE5); rd(3, d); chk("R2 uv hyst mask", d, 8'h05);
      wr(4, 8'h0B); rd(4, d); chk("R2 sel bit3", d, 8'h03);
      wr(5, 8'hAA); rd(5, d); chk("R2 addr5", d, 0);
      rd(7, d); chk("R2 addr7", d, 0);
      wr(0, 8'h5A); rd(0, d); chk("R2 ov thr rw", d, 8'h5A);

      // R3 upper flag with hysteresis, R7 pass-through
      cfg(100, 10, 0, 0, 8'h00);
      smp(100); chk("R3 equal no trip", fault_out, 0);
      smp(101); chk("R7 trip passthrough", fault_out, 1);
      smp(95);  chk("R3 hold in band", fault_out, 1);
      smp(90);  chk("R3 at release lvl", fault_out, 1);
      smp(89);  chk("R3 released", fault_out, 0);
      // R3 floor at 0
      cfg(5, 20, 0, 0, 8'h00);
      smp(6); chk("R3 low trip", fault_out, 1);
      smp(0); chk("R3 floor holds", fault_out, 1);
      wr(0, 200); smp(0); chk("R3 clear after thr change", fault_out, 0);

      // R4 lower flag with hysteresis and cap
      cfg(255, 0, 50, 10, 8'h01);
      smp(50); chk("R4 equal no trip", fault_out, 0);
      smp(49); chk("R4 trip", fault_out, 1);
      smp(60); chk("R4 hold at lvl", fault_out, 1);
      smp(61); chk("R4 released", fault_out, 0);
      cfg(255, 0, 250, 31, 8'h01);
      smp(249); chk("R4 high trip", fault_out, 1);
      smp(255); chk("R4 cap holds", fault_out, 1);
      wr(2, 0); smp(255); chk("R4 clear after thr change", fault_out, 0);

      // R5 window and type selection
      cfg(200, 0, 50, 0, 8'h02);
      smp(201); chk("R5 window upper", fault_out, 1);
      smp(100); chk("R5 window clear", fault_out, 0);
      smp(10);  chk("R5 window lower", fault_out, 1);
      wr(4, 8'h00); #1 chk("R5 type over ignores lower", fault_out, 0);
      smp(100);

      // R6 forbidden type
      cfg(100, 0, 50, 0, 8'h03);
      smp(255); chk("R6 over masked", fault_out, 0);
      smp(0);   chk("R6 under masked", fault_out, 0);
      smp(75);

      // R8 delay code 1 = 5 us
      cfg(100, 0, 0, 0, 8'h10);
      smp(200); chk("R8 not yet", fault_out, 0);
      for (int i = 1; i < 5 * CPU; i++) begin
         @(negedge clk); chk("R8 still waiting", fault_out, 0);
      end
      @(negedge clk); chk("R8 asserts at delay", fault_out, 1);
      smp(50); chk("R8 drops at once", fault_out, 0);

      // R9 range indication
      wr(4, 8'h04); chk("R9 positive high range", range_hi, 1);
      wr(4, 8'h84); chk("R9 negative ignores rsel", range_hi, 0);
      wr(4, 8'h00); chk("R9 low range", range_hi, 0);

      // random phase against model
      for (int s = 0; s < 40; s++) begin
         int sel;
         sel = $urandom_range(0, 255);
         if (s % 5 == 0) sel = sel & 8'h8F;
         cfg($urandom_range(0, 255), $urandom_range(0, 255),
             $urandom_range(0, 255), $urandom_range(0, 255), sel);
         for (int r = 0; r < 4; r++) begin
            int c, len;
            c   = $urandom_range(0, 255);
            len = $urandom_range(1, 260);
            @(negedge clk);
            smp_vld = 1'b1; smp_code = 8'(c);
            repeat (len) @(negedge clk);
            smp_vld = 1'b0;
         end
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule